// File: doc/BRIEF.md
# Edge Coverage Anti-Aliasing Tile Buffer

This block keeps a small on-chip tile of pixel records and updates them from a stream of rasterized fragments, so that polygon boundaries are anti-aliased at a fraction of the storage of full supersampling. Each pixel holds one background sample (color and depth), one edge sample (color and depth) and a 4-bit coverage value. Interior fragments go to the background. Fragments flagged as lying on a polygon boundary go to the edge layer. When a new boundary fragment lands on a pixel that already has an edge, the old edge is folded into the background at once, weighted by its coverage. Edges formed where two surfaces cross in depth are not smoothed.

Updates run through a three-stage read-modify-write pipeline. A clear command fills the tile with a chosen color at the farthest depth. A resolve command sweeps the tile in raster order and streams out one final color per pixel, with the edge blended over the background by coverage. Fragments enter on a valid/ready port. `in_ready` may fall in the same cycle as `in_addr` changes, because it depends on the address of the offered fragment. A fragment is taken on a clock edge where `in_valid` and `in_ready` are both high, and the source holds it steady until then. Resolved pixels leave on a valid/ready port. `out_color` and `out_last` stay unchanged while `out_valid` is high and `out_ready` is low. A clear or resolve request is honoured only while `busy` is low. A request that arrives while `busy` is high is dropped.

Top module: `edge_aa_tile`

## Requirements
- R1: After reset every pixel has background color 0, depth all-ones and coverage 0, so it resolves to 0. `in_ready` is high while no command is requested, and `busy` and `out_valid` are low.
- R2: A fragment with `in_edge`=0 at a pixel whose coverage is 0 replaces the background color and depth if its depth is strictly less (unsigned) than the background depth. An equal or greater depth leaves the pixel unchanged.
- R3: A fragment with `in_edge`=1, coverage 1 to 15 and a passing depth test at a pixel with coverage 0 stores its color, depth and coverage in the edge layer and leaves the background unchanged. An edge fragment with coverage 0 is discarded.
- R4: An edge fragment that passes at a pixel whose coverage is non-zero first replaces the background color with the blend of the old edge over it (using the old coverage) and the background depth with the old edge depth. It then stores itself as the edge.
- R5: A non-edge fragment strictly nearer than the stored edge depth at a pixel with non-zero coverage replaces the background color and depth and sets coverage to 0.
- R6: A non-edge fragment that is not nearer than the stored edge depth but strictly nearer than the background depth replaces only the background color and depth. The edge layer and coverage are kept.
- R7: A fragment is tested against the nearest valid layer: the edge depth if coverage is non-zero, otherwise the background depth. An edge fragment that fails this test is discarded.
- R8: The resolved color is computed independently for each byte channel, bits [8k+7:8k], as (edge·cov + background·(16−cov)) >> 4. Coverage 0 returns the background color unchanged.
- R9: A `resolve_req` pulse while idle raises `busy` and streams TILE_W·TILE_H pixels in ascending address order, where address = y·TILE_W + x. `out_last` is high only on the final pixel. While `out_valid` is high and `out_ready` is low, `out_color` and `out_last` hold.
- R10: A `clear_req` pulse while idle sets every pixel to background color `clear_color`, depth all-ones and coverage 0. This removes any edge.
- R11: `in_ready` is low while `busy` is high, while a request is asserted, and while `in_addr` matches a fragment still in the pipeline. Fragments to the same pixel take effect in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fragment offered |
| in_ready | output | 1 | Fragment can be taken this cycle |
| in_addr | input | log2(TILE_W·TILE_H) | Pixel address, y·TILE_W + x |
| in_color | input | 32 | Fragment color, four byte channels |
| in_depth | input | 32 | Fragment depth, smaller is nearer |
| in_edge | input | 1 | Fragment lies on a polygon boundary |
| in_cov | input | 4 | Boundary coverage, 0 to 15 |
| clear_req | input | 1 | Start a tile clear |
| clear_color | input | 32 | Background color written by a clear |
| resolve_req | input | 1 | Start a resolve sweep |
| busy | output | 1 | A clear or resolve is draining or running |
| out_valid | output | 1 | Resolved pixel available |
| out_ready | input | 1 | Consumer takes the resolved pixel |
| out_color | output | 32 | Resolved pixel color |
| out_last | output | 1 | Marks the final pixel of a sweep |

## Verification
A corrupted pixel record is invisible until the next resolve sweep reaches that address, which can be several hundred cycles after the faulty update. For that reason every stimulus step is followed by a full sweep, and the affected pixel is compared before the next fragment arrives. A wrong stored depth never shows in the color directly. It appears only when a later fragment at the same pixel is wrongly kept or wrongly dropped, so the stimulus sequences place fragments at depths just in front of, equal to and just behind each stored layer. A broken address-hazard stall shows as a lost update on back-to-back fragments to one pixel. It is also seen directly as `in_ready` staying high in the cycle after a same-address acceptance.

// File: rtl/eaa_pkg.sv
package eaa_pkg;
  parameter int PIX_COLOR_W = 32;
  parameter int PIX_DEPTH_W = 32;
  parameter int COV_W       = 4;
  localparam int CHAN_W     = 8;

  localparam logic [PIX_DEPTH_W-1:0] DEPTH_FAR = '1;

  typedef struct packed {
    logic [PIX_COLOR_W-1:0] bg_color;
    logic [PIX_DEPTH_W-1:0] bg_depth;
    logic [PIX_COLOR_W-1:0] ed_color;
    logic [PIX_DEPTH_W-1:0] ed_depth;
    logic [COV_W-1:0]       cov;
  } pix_rec_t;

  typedef struct packed {
    logic [PIX_COLOR_W-1:0] color;
    logic [PIX_DEPTH_W-1:0] depth;
    logic                   is_edge;
    logic [COV_W-1:0]       cov;
  } frag_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_DRAIN,
    SEQ_CLEAR,
    SEQ_RESOLVE
  } seq_state_t;
endpackage

// File: rtl/eaa_blend.sv
module eaa_blend import eaa_pkg::*; #(
  parameter int COLOR_W = PIX_COLOR_W
) (
  input  logic [COLOR_W-1:0] fg_color,
  input  logic [COLOR_W-1:0] bg_color,
  input  logic [COV_W-1:0]   cov,
  output logic [COLOR_W-1:0] mix_color
);
  localparam int NCH    = COLOR_W / CHAN_W;
  localparam int PROD_W = CHAN_W + COV_W + 1;
  localparam logic [PROD_W-1:0] FULL_W = PROD_W'(1) << COV_W;

  // One weighted sum per byte channel; weights add up to 2^COV_W.
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [PROD_W-1:0] fg_term;
    logic [PROD_W-1:0] bg_term;
    logic [PROD_W-1:0] sum;
    always_comb begin
      fg_term = PROD_W'(fg_color[ch*CHAN_W +: CHAN_W]) * PROD_W'(cov);
      bg_term = PROD_W'(bg_color[ch*CHAN_W +: CHAN_W]) * (FULL_W - PROD_W'(cov));
      sum     = fg_term + bg_term;
      mix_color[ch*CHAN_W +: CHAN_W] = sum[COV_W +: CHAN_W];
    end
  end
endmodule

// File: rtl/eaa_pixel_store.sv
module eaa_pixel_store import eaa_pkg::*; #(
  parameter int ENTRIES = 256,
  parameter int ADDR_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  pix_rec_t          wr_rec,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output pix_rec_t          rd_a_rec,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output pix_rec_t          rd_b_rec
);
  localparam pix_rec_t INIT_REC = '{bg_color: '0, bg_depth: DEPTH_FAR,
                                    ed_color: '0, ed_depth: DEPTH_FAR, cov: '0};

  pix_rec_t mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= INIT_REC;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_rec;
    end
  end

  // Combinational read ports: A feeds the update pipe, B feeds the sweep.
  always_comb begin
    rd_a_rec = (int'(rd_a_addr) < ENTRIES) ? mem[rd_a_addr] : INIT_REC;
    rd_b_rec = (int'(rd_b_addr) < ENTRIES) ? mem[rd_b_addr] : INIT_REC;
  end

  AST_WR_IN_TILE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_addr) < ENTRIES); // R10
endmodule

// File: rtl/eaa_merge.sv
module eaa_merge import eaa_pkg::*; (
  input  pix_rec_t old_rec,
  input  frag_t    frag,
  output pix_rec_t new_rec,
  output logic     keep
);
  logic                   ed_live;
  logic [PIX_DEPTH_W-1:0] near_z;
  logic [PIX_COLOR_W-1:0] folded_color;

  assign ed_live = (old_rec.cov != '0);
  assign near_z  = ed_live ? old_rec.ed_depth : old_rec.bg_depth;

  // Old edge folded over the background, used when the edge is displaced.
  eaa_blend #(.COLOR_W(PIX_COLOR_W)) u_fold (
    .fg_color (old_rec.ed_color),
    .bg_color (old_rec.bg_color),
    .cov      (old_rec.cov),
    .mix_color(folded_color)
  );

  always_comb begin
    new_rec = old_rec;
    keep    = 1'b0;
    if (frag.is_edge) begin
      if (frag.cov != '0 && frag.depth < near_z) begin
        keep = 1'b1;
        if (ed_live) begin
          new_rec.bg_color = folded_color;
          new_rec.bg_depth = old_rec.ed_depth;
        end
        new_rec.ed_color = frag.color;
        new_rec.ed_depth = frag.depth;
        new_rec.cov      = frag.cov;
      end
    end else if (frag.depth < old_rec.bg_depth) begin
      keep             = 1'b1;
      new_rec.bg_color = frag.color;
      new_rec.bg_depth = frag.depth;
      if (ed_live && frag.depth < old_rec.ed_depth) new_rec.cov = '0;
    end
  end
endmodule

// File: rtl/edge_aa_tile.sv
module edge_aa_tile import eaa_pkg::*; #(
  parameter int TILE_W = 16,
  parameter int TILE_H = 16,
  localparam int PIXELS = TILE_W * TILE_H,
  localparam int ADDR_W = $clog2(PIXELS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [ADDR_W-1:0]      in_addr,
  input  logic [PIX_COLOR_W-1:0] in_color,
  input  logic [PIX_DEPTH_W-1:0] in_depth,
  input  logic                   in_edge,
  input  logic [COV_W-1:0]       in_cov,
  input  logic                   clear_req,
  input  logic [PIX_COLOR_W-1:0] clear_color,
  input  logic                   resolve_req,
  output logic                   busy,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PIX_COLOR_W-1:0] out_color,
  output logic                   out_last
);
  localparam int CNT_W = $clog2(PIXELS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(PIXELS - 1);
  localparam logic [CNT_W-1:0] PIX_COUNT = CNT_W'(PIXELS);

  seq_state_t             state;
  logic [CNT_W-1:0]       idx;
  logic                   cmd_clear;
  logic [PIX_COLOR_W-1:0] clr_color_q;

  logic                   s1_v;
  logic [ADDR_W-1:0]      s1_addr;
  frag_t                  s1_frag;
  pix_rec_t               s1_rec;
  logic                   s2_v;
  logic [ADDR_W-1:0]      s2_addr;
  pix_rec_t               s2_rec;
  logic                   s2_keep;

  pix_rec_t               rd_a_rec, rd_b_rec, mrg_rec, wr_rec, clr_rec;
  logic                   mrg_keep, wr_en, hazard, accept, pipe_empty, sweep_load;
  logic [ADDR_W-1:0]      wr_addr, rd_b_addr;
  logic [PIX_COLOR_W-1:0] res_color;
  logic                   sweep_unused;

  // ---------------- input handshake and hazard stall ----------------
  always_comb begin
    hazard     = (s1_v && s1_addr == in_addr) || (s2_v && s2_addr == in_addr);
    in_ready   = (state == SEQ_IDLE) && !clear_req && !resolve_req && !hazard;
    accept     = in_valid && in_ready;
    pipe_empty = !s1_v && !s2_v;
    busy       = (state != SEQ_IDLE);
  end

  // ---------------- tile storage ----------------
  assign clr_rec = '{bg_color: clr_color_q, bg_depth: DEPTH_FAR,
                     ed_color: '0, ed_depth: DEPTH_FAR, cov: '0};

  always_comb begin
    if (state == SEQ_CLEAR) begin
      wr_en   = 1'b1;
      wr_addr = idx[ADDR_W-1:0];
      wr_rec  = clr_rec;
    end else begin
      wr_en   = s2_v && s2_keep;
      wr_addr = s2_addr;
      wr_rec  = s2_rec;
    end
    rd_b_addr = (idx < PIX_COUNT) ? idx[ADDR_W-1:0] : '0;
  end

  eaa_pixel_store #(.ENTRIES(PIXELS), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_rec   (wr_rec),
    .rd_a_addr(in_addr),
    .rd_a_rec (rd_a_rec),
    .rd_b_addr(rd_b_addr),
    .rd_b_rec (rd_b_rec)
  );

  // ---------------- update pipeline: read / merge / write ----------------
  eaa_merge u_merge (
    .old_rec(s1_rec),
    .frag   (s1_frag),
    .new_rec(mrg_rec),
    .keep   (mrg_keep)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_addr <= '0;
      s1_frag <= '0;
      s1_rec  <= '0;
      s2_v    <= 1'b0;
      s2_addr <= '0;
      s2_rec  <= '0;
      s2_keep <= 1'b0;
    end else begin
      s1_v <= accept;
      if (accept) begin
        s1_addr <= in_addr;
        s1_frag <= '{color: in_color, depth: in_depth, is_edge: in_edge, cov: in_cov};
        s1_rec  <= rd_a_rec;
      end
      s2_v <= s1_v;
      if (s1_v) begin
        s2_addr <= s1_addr;
        s2_rec  <= mrg_rec;
        s2_keep <= mrg_keep;
      end
    end
  end

  // ---------------- command sequencer and resolve stream ----------------
  eaa_blend #(.COLOR_W(PIX_COLOR_W)) u_resolve_mix (
    .fg_color (rd_b_rec.ed_color),
    .bg_color (rd_b_rec.bg_color),
    .cov      (rd_b_rec.cov),
    .mix_color(res_color)
  );
  assign sweep_unused = ^{rd_b_rec.bg_depth, rd_b_rec.ed_depth};

  assign sweep_load = (state == SEQ_RESOLVE) && (idx < PIX_COUNT) && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SEQ_IDLE;
      idx         <= '0;
      cmd_clear   <= 1'b0;
      clr_color_q <= '0;
      out_valid   <= 1'b0;
      out_color   <= '0;
      out_last    <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (clear_req) begin
            state       <= SEQ_DRAIN;
            cmd_clear   <= 1'b1;
            clr_color_q <= clear_color;
          end else if (resolve_req) begin
            state     <= SEQ_DRAIN;
            cmd_clear <= 1'b0;
          end
        end
        SEQ_DRAIN: begin
          if (pipe_empty) begin
            state <= cmd_clear ? SEQ_CLEAR : SEQ_RESOLVE;
            idx   <= '0;
          end
        end
        SEQ_CLEAR: begin
          idx <= idx + 1'b1;
          if (idx == LAST_IDX) state <= SEQ_IDLE;
        end
        SEQ_RESOLVE: begin
          if (sweep_load) begin
            out_valid <= 1'b1;
            out_color <= res_color;
            out_last  <= (idx == LAST_IDX);
            idx       <= idx + 1'b1;
          end else if (out_ready) begin
            out_valid <= 1'b0;
          end
          if (out_valid && out_ready && out_last) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_color) && $stable(out_last)); // R9
  AST_LAST_ENDS_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && !busy); // R9
  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready); // R11
  AST_SWEEP_PIPE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_CLEAR || state == SEQ_RESOLVE) |-> !s1_v && !s2_v); // R10
  AST_EDGE_IN_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && s1_rec.cov != '0 |-> s1_rec.ed_depth <= s1_rec.bg_depth); // R6
  AST_NEAR_DROPS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && !s1_frag.is_edge && s1_frag.depth < s1_rec.ed_depth &&
    s1_frag.depth < s1_rec.bg_depth |-> mrg_keep && mrg_rec.cov == '0); // R5
  AST_EDGE_KEEPS_BG: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && s1_frag.is_edge && s1_rec.cov == '0 |->
    mrg_rec.bg_color == s1_rec.bg_color && mrg_rec.bg_depth == s1_rec.bg_depth); // R3
endmodule

// File: tb/tb_edge_aa_tile.sv
module tb_edge_aa_tile;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NPIX = 256;
  localparam int NV   = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_addr = '0;
  logic [31:0] in_color = '0;
  logic [31:0] in_depth = '0;
  logic        in_edge = 1'b0;
  logic [3:0]  in_cov = '0;
  logic        clear_req = 1'b0;
  logic [31:0] clear_color = '0;
  logic        resolve_req = 1'b0;
  logic        busy;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_color;
  logic        out_last;

  int vectors = 0;
  int errs    = 0;
  logic [31:0] frame [NPIX];

  always #10 clk = ~clk;

  edge_aa_tile dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_color(in_color), .in_depth(in_depth), .in_edge(in_edge),
    .in_cov(in_cov), .clear_req(clear_req), .clear_color(clear_color),
    .resolve_req(resolve_req), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_color(out_color), .out_last(out_last)
  );

  // {req id, addr, color, depth, edge, cov, expected resolved color at addr}
  localparam logic [112:0] TBL [NV] = '{
    {4'd2, 8'd5,   32'h10101010, 32'd100,        1'b0, 4'd0,  32'h10101010},
    {4'd3, 8'd5,   32'hF0F0F0F0, 32'd50,         1'b1, 4'd4,  32'h48484848},
    {4'd6, 8'd5,   32'h20202020, 32'd80,         1'b0, 4'd0,  32'h54545454},
    {4'd7, 8'd5,   32'h30303030, 32'd120,        1'b0, 4'd0,  32'h54545454},
    {4'd4, 8'd5,   32'h00000000, 32'd40,         1'b1, 4'd8,  32'h2A2A2A2A},
    {4'd7, 8'd5,   32'hFFFFFFFF, 32'd45,         1'b1, 4'd15, 32'h2A2A2A2A},
    {4'd5, 8'd5,   32'h66666666, 32'd30,         1'b0, 4'd0,  32'h66666666},
    {4'd2, 8'd5,   32'h77777777, 32'd30,         1'b0, 4'd0,  32'h66666666},
    {4'd3, 8'd5,   32'h99999999, 32'd10,         1'b1, 4'd0,  32'h66666666},
    {4'd8, 8'd5,   32'hFFFFFFFF, 32'd10,         1'b1, 4'd15, 32'hF5F5F5F5},
    {4'd8, 8'd255, 32'hFFFFFFFF, 32'd10,         1'b1, 4'd1,  32'h0F0F0F0F},
    {4'd2, 8'd0,   32'h12345678, 32'hFFFFFFFE,   1'b0, 4'd0,  32'h12345678},
    {4'd8, 8'd0,   32'h00FF00FF, 32'd1,          1'b1, 4'd8,  32'h09992BBB},
    {4'd2, 8'd1,   32'hABABABAB, 32'hFFFFFFFF,   1'b0, 4'd0,  32'h00000000}
  };

  function automatic string req_tag(input logic [3:0] id);
    case (id)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; offers a fragment without waiting.
  task automatic offer(input logic [7:0] a, input logic [31:0] c, input logic [31:0] z,
                       input logic e, input logic [3:0] cv);
    in_addr = a; in_color = c; in_depth = z; in_edge = e; in_cov = cv; in_valid = 1'b1;
  endtask

  // Waits for acceptance, returns at the following negedge with in_valid low.
  task automatic finish_offer();
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic push(input logic [7:0] a, input logic [31:0] c, input logic [31:0] z,
                      input logic e, input logic [3:0] cv);
    offer(a, c, z, e, cv);
    finish_offer();
  endtask

  task automatic run_clear(input logic [31:0] c);
    clear_color = c;
    clear_req = 1'b1;
    @(negedge clk);
    clear_req = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // Sweeps the tile into frame[]; called and returning at a negedge.
  task automatic run_resolve(input bit bp, output int n_px, output int last_pos,
                             output int hold_err);
    bit          done = 0;
    bit          held = 0;
    logic [31:0] held_c = '0;
    int          cyc = 0;
    n_px = 0; last_pos = -1; hold_err = 0;
    resolve_req = 1'b1;
    @(negedge clk);
    resolve_req = 1'b0;
    #1;
    chk("R11", "in_ready while busy", {31'd0, in_ready}, 32'd0);
    chk("R9", "busy after resolve request", {31'd0, busy}, 32'd1);
    while (!done) begin
      out_ready = bp ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (held) begin
        if (!out_valid || out_color !== held_c) hold_err++;
        held = 0;
      end
      if (out_valid && out_ready) begin
        if (n_px < NPIX) frame[n_px] = out_color;
        if (out_last) begin
          last_pos = n_px;
          done = 1;
        end
        n_px++;
      end else if (out_valid) begin
        held = 1;
        held_c = out_color;
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    int n, lp, he, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state at the ports
    chk("R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);
    chk("R1", "busy after reset", {31'd0, busy}, 32'd0);
    chk("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    run_resolve(0, n, lp, he);
    bad = 0;
    for (int i = 0; i < NPIX; i++) if (frame[i] !== 32'h0) bad++;
    chk("R1", "non-zero pixels after reset", bad, 0);
    chk("R9", "pixel count", n, NPIX);
    chk("R9", "position of last flag", lp, NPIX - 1);

    // Table walk: one fragment, then a full sweep, then check its pixel.
    for (int v = 0; v < NV; v++) begin
      push(TBL[v][108:101], TBL[v][100:69], TBL[v][68:37], TBL[v][36], TBL[v][35:32]);
      run_resolve(0, n, lp, he);
      chk(req_tag(TBL[v][112:109]), $sformatf("vector %0d pixel", v),
          frame[TBL[v][108:101]], TBL[v][31:0]);
    end

    // R11: same-address hazard stall and ordering
    offer(8'd7, 32'h11111111, 32'd100, 1'b0, 4'd0);
    finish_offer();
    offer(8'd7, 32'h22222222, 32'd50, 1'b0, 4'd0);
    #1;
    chk("R11", "in_ready with same address in flight", {31'd0, in_ready}, 32'd0);
    finish_offer();
    push(8'd7, 32'h00000000, 32'd40, 1'b1, 4'd8);
    offer(8'd8, 32'h5A5A5A5A, 32'd5, 1'b0, 4'd0);
    #1;
    chk("R11", "in_ready with other address in flight", {31'd0, in_ready}, 32'd1);
    finish_offer();

    // R9: sweep under back-pressure
    run_resolve(1, n, lp, he);
    chk("R11", "pixel 7 after ordered updates", frame[7], 32'h11111111);
    chk("R11", "pixel 8", frame[8], 32'h5A5A5A5A);
    chk("R8", "pixel 5 kept", frame[5], 32'hF5F5F5F5);
    chk("R9", "pixel count under back-pressure", n, NPIX);
    chk("R9", "last flag position under back-pressure", lp, NPIX - 1);
    chk("R9", "output hold violations", he, 0);

    // R10: clear removes backgrounds and edges everywhere
    run_clear(32'hA5A5A5A5);
    chk("R10", "busy after clear", {31'd0, busy}, 32'd0);
    run_resolve(0, n, lp, he);
    bad = 0;
    for (int i = 0; i < NPIX; i++) if (frame[i] !== 32'hA5A5A5A5) bad++;
    chk("R10", "pixels not at clear color", bad, 0);
    chk("R10", "edge pixel 255 after clear", frame[255], 32'hA5A5A5A5);
    // After a clear the depth is far again: any finite depth is accepted.
    push(8'd9, 32'h3C3C3C3C, 32'hFFFFFFF0, 1'b0, 4'd0);
    run_resolve(0, n, lp, he);
    chk("R10", "pixel 9 after clear and write", frame[9], 32'h3C3C3C3C);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule